// File: doc/BRIEF.md
# Load-Aware Destination Allocation Agent

This block lives inside the network interface of one processing element and decides, once per allocation period, which of several identical downstream elements receives this node's data next. Candidate destinations send short control packets that carry their current count of free receive slots and their hop distance to this node. The agent queues these reports, and once a fixed collection window has closed it scores every queued report with a shift-only fitness function. The best-scoring address becomes the destination for the following period. A candidate that stays silent during the window is simply not scored, so traffic moves away from an element that has failed or stalled.

The agent also plays the other role. At the start of every period it sends one report to each of its own potential sources, taken from a build-time table of source addresses and hop counts, with its own live free-slot count. The period length `INTERVAL`, the window length `WINDOW` (default 10 cycles), the queue depth and the table are parameters. The two fitness weights are inputs that the surrounding configuration logic holds steady.

Top module: `load_alloc_agent`

## Requirements
- R1: While reset is held and just after it, `dest_valid` is 0, `dest_addr` is 0 and `ctl_out_valid` is 0. No report is sent during the first period after reset.
- R2: Each queued report is scored as (slots shifted left by `wt_l`) minus (hops shifted left by `wt_k`). The address with the largest score becomes the next destination.
- R3: When two reports have equal scores, the one that arrived earlier wins.
- R4: The first report accepted in a period opens a window of `WINDOW` cycles, counted from and including the cycle of that report. Reports sampled at offsets 0 to `WINDOW`-1 from it are queued. A report at offset `WINDOW` or later is not scored.
- R5: If a period receives no report, `dest_addr` and `dest_valid` keep their previous values. `dest_valid` stays 0 until the first winner exists and stays 1 after that.
- R6: `dest_addr` and `dest_valid` change only on the clock edge that ends a period, that is, the edge where the period counter, which starts at 0 after reset, has reached `INTERVAL`-1. The new value is the winner chosen during the period that is ending.
- R7: Starting with the edge that ends each period, `ctl_out_valid` is high for `NSRC` consecutive cycles. Entry i comes from the build-time table in order i = 0, 1, 2 (defaults: addresses 12, 7, 3 with hops 5, 2, 1), and `ctl_out_slots` equals `local_slots`.
- R8: At most `QDEPTH` reports (default 4) are queued per period. Any further report inside the window is dropped and is not scored.
- R9: A report presented on the period-ending edge is ignored and does not open a window in the new period. A report that arrives after the window has closed is also ignored.
- R10: The scores are signed. A report whose hop term exceeds its slot term still competes, and the least negative score wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_in_valid | input | 1 | Incoming load report present this cycle |
| ctl_in_addr | input | ADDR_W | Address of the reporting candidate |
| ctl_in_slots | input | SLOT_W | Free receive slots of the candidate |
| ctl_in_hops | input | HOP_W | Hop distance carried in the report |
| wt_l | input | WT_W | Left-shift weight applied to the slot count |
| wt_k | input | WT_W | Left-shift weight applied to the hop count |
| local_slots | input | SLOT_W | This node's own free receive slots |
| ctl_out_valid | output | 1 | Outgoing load report request |
| ctl_out_addr | output | ADDR_W | Source element addressed by the outgoing report |
| ctl_out_slots | output | SLOT_W | Free-slot count sent in the outgoing report |
| ctl_out_hops | output | HOP_W | Hop distance sent in the outgoing report |
| dest_addr | output | ADDR_W | Selected destination for the current period |
| dest_valid | output | 1 | A destination has been selected |

## Verification
The assertions assume that the weights do not change while a search is running. They also assume that `INTERVAL` is long enough for the window, the search and a finishing cycle to end before the period does. The stimulus changes the weights only between periods and uses the default 64-cycle period, which leaves wide margin over the 10-cycle window and the 4-entry queue. The reports are placed at chosen offsets from the period counter: at the window edge, beyond the queue capacity, on the period-ending edge and long after the window. A bench model of the period, the window, the queue and the running maximum is compared with the outputs on every cycle.

// File: rtl/load_alloc_agent.sv
module load_alloc_agent #(
  parameter int ADDR_W   = 4,
  parameter int SLOT_W   = 6,
  parameter int HOP_W    = 4,
  parameter int WT_W     = 3,
  parameter int NSRC     = 3,
  parameter int QDEPTH   = 4,
  parameter int INTERVAL = 64,
  parameter int WINDOW   = 10,
  parameter logic [NSRC*ADDR_W-1:0] SRC_ADDRS = {4'd3, 4'd7, 4'd12},
  parameter logic [NSRC*HOP_W-1:0]  SRC_HOPS  = {4'd1, 4'd2, 4'd5}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_in_valid,
  input  logic [ADDR_W-1:0] ctl_in_addr,
  input  logic [SLOT_W-1:0] ctl_in_slots,
  input  logic [HOP_W-1:0]  ctl_in_hops,
  input  logic [WT_W-1:0]   wt_l,
  input  logic [WT_W-1:0]   wt_k,
  input  logic [SLOT_W-1:0] local_slots,
  output logic              ctl_out_valid,
  output logic [ADDR_W-1:0] ctl_out_addr,
  output logic [SLOT_W-1:0] ctl_out_slots,
  output logic [HOP_W-1:0]  ctl_out_hops,
  output logic [ADDR_W-1:0] dest_addr,
  output logic              dest_valid
);
  localparam int MAXSH = (1 << WT_W) - 1;
  localparam int SPAN  = (SLOT_W > HOP_W) ? SLOT_W : HOP_W;
  localparam int FW    = SPAN + MAXSH + 2;
  localparam int E_W   = ADDR_W + SLOT_W + HOP_W;
  localparam int T_W   = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int W_W   = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int QI_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QC_W  = $clog2(QDEPTH + 1);
  localparam int B_W   = $clog2(NSRC + 1);
  localparam logic [T_W-1:0]  TLAST = T_W'(INTERVAL - 1);
  localparam logic [W_W-1:0]  WLAST = W_W'(WINDOW - 1);
  localparam logic [QI_W-1:0] QLAST = QI_W'(QDEPTH - 1);
  localparam logic [QC_W-1:0] QFULL = QC_W'(QDEPTH);
  localparam logic [B_W-1:0]  BEND  = B_W'(NSRC);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_SEARCH, ST_HOLD} phase_t;

  phase_t            st;
  logic [T_W-1:0]    tcnt;
  logic [W_W-1:0]    timer;
  logic [B_W-1:0]    bidx;
  logic [E_W-1:0]    q_mem [QDEPTH];
  logic [QI_W-1:0]   wp, rp;
  logic [QC_W-1:0]   qcount;
  logic signed [FW-1:0] best_fit;
  logic [ADDR_W-1:0] best_addr;
  logic              have_best;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_valid;

  wire tick = (tcnt == TLAST);

  wire open_ok = (st == ST_IDLE) || (st == ST_COLLECT && timer != '0);
  wire push = ctl_in_valid && !tick && open_ok && (qcount < QFULL);
  wire pop  = !tick && (st == ST_SEARCH) && (qcount != '0);

  wire [E_W-1:0]    head    = q_mem[rp];
  wire [ADDR_W-1:0] h_addr  = head[E_W-1 -: ADDR_W];
  wire [SLOT_W-1:0] h_slots = head[HOP_W +: SLOT_W];
  wire [HOP_W-1:0]  h_hops  = head[HOP_W-1:0];

  logic signed [FW-1:0] s_term, h_term, cur_fit;
  assign s_term  = $signed({{(FW-SLOT_W){1'b0}}, h_slots}) <<< wt_l;
  assign h_term  = $signed({{(FW-HOP_W){1'b0}}, h_hops}) <<< wt_k;
  assign cur_fit = s_term - h_term;

  wire better = !have_best || (cur_fit > best_fit);

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              bidx <= BEND;
    else if (tick)           bidx <= '0;
    else if (bidx < BEND)    bidx <= bidx + 1'b1;
  end

  wire [B_W-1:0] bsel = (bidx < BEND) ? bidx : '0;
  assign ctl_out_valid = (bidx < BEND);
  assign ctl_out_addr  = SRC_ADDRS[bsel*ADDR_W +: ADDR_W];
  assign ctl_out_hops  = SRC_HOPS[bsel*HOP_W +: HOP_W];
  assign ctl_out_slots = local_slots;

  always_ff @(posedge clk) begin
    if (push) q_mem[wp] <= {ctl_in_addr, ctl_in_slots, ctl_in_hops};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tick) begin
      wp <= '0;
      rp <= '0;
      qcount <= '0;
    end else begin
      if (push) begin
        wp <= (wp == QLAST) ? '0 : wp + 1'b1;
        qcount <= qcount + 1'b1;
      end
      if (pop) begin
        rp <= (rp == QLAST) ? '0 : rp + 1'b1;
        qcount <= qcount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      timer <= '0;
      have_best <= 1'b0;
      best_fit <= '0;
      best_addr <= '0;
      pend_addr <= '0;
      pend_valid <= 1'b0;
      dest_addr <= '0;
      dest_valid <= 1'b0;
    end else if (tick) begin
      st <= ST_IDLE;
      have_best <= 1'b0;
      pend_valid <= 1'b0;
      if (pend_valid) begin
        dest_addr <= pend_addr;
        dest_valid <= 1'b1;
      end
    end else begin
      case (st)
        ST_IDLE: if (ctl_in_valid) begin
          timer <= WLAST;
          st <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (timer != '0) timer <= timer - 1'b1;
          else             st <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (pop) begin
            have_best <= 1'b1;
            if (better) begin
              best_fit <= cur_fit;
              best_addr <= h_addr;
            end
          end else begin
            pend_addr <= best_addr;
            pend_valid <= have_best;
            st <= ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  // R6
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dest_addr) && $stable(dest_valid)));

  // R5
  dest_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dest_valid |=> dest_valid);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qcount <= QFULL);

  // R2
  best_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (best_fit >= $past(cur_fit)));

  // R3
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && have_best && cur_fit == best_fit) |=> $stable(best_addr));

  // R9
  tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (qcount == '0 && st == ST_IDLE));

  // R7
  bcast_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ctl_out_valid);
endmodule

// File: tb/tb_load_alloc_agent.sv
module tb_load_alloc_agent;
  localparam int INTERVAL = 64;
  localparam int WINDOW   = 10;
  localparam int QDEPTH   = 4;
  localparam int NSRC     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_in_valid = 1'b0;
  logic [3:0] ctl_in_addr = '0;
  logic [5:0] ctl_in_slots = '0;
  logic [3:0] ctl_in_hops = '0;
  logic [2:0] wt_l = '0, wt_k = '0;
  logic [5:0] local_slots = 6'd17;
  logic ctl_out_valid, dest_valid;
  logic [3:0] ctl_out_addr, ctl_out_hops, dest_addr;
  logic [5:0] ctl_out_slots;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  load_alloc_agent dut (
    .clk(clk), .rst_n(rst_n), .ctl_in_valid(ctl_in_valid), .ctl_in_addr(ctl_in_addr),
    .ctl_in_slots(ctl_in_slots), .ctl_in_hops(ctl_in_hops), .wt_l(wt_l), .wt_k(wt_k),
    .local_slots(local_slots), .ctl_out_valid(ctl_out_valid), .ctl_out_addr(ctl_out_addr),
    .ctl_out_slots(ctl_out_slots), .ctl_out_hops(ctl_out_hops),
    .dest_addr(dest_addr), .dest_valid(dest_valid));

  int tbl_addr [NSRC] = '{12, 7, 3};
  int tbl_hop  [NSRC] = '{5, 2, 1};

  int mt = 0, mb = NSRC, mph = 0, mtim = 0;
  int md = 0, mdv = 0, mpa = 0, mpv = 0, ba = 0, bf = 0, first = 1;
  int qa[$], qs[$], qh[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = 0; mb = NSRC; mph = 0; md = 0; mdv = 0; mpv = 0;
      qa.delete(); qs.delete(); qh.delete();
    end else begin
      bit tk;
      tk = (mt == INTERVAL - 1);
      if (tk) mb = 0; else if (mb < NSRC) mb++;
      if (tk) begin
        if (mpv != 0) begin md = mpa; mdv = 1; end
        mpv = 0; mph = 0;
        qa.delete(); qs.delete(); qh.delete();
      end else begin
        case (mph)
          0: if (ctl_in_valid) begin
               qa.push_back(ctl_in_addr); qs.push_back(ctl_in_slots); qh.push_back(ctl_in_hops);
               mtim = WINDOW - 1; mph = 1; first = 1;
             end
          1: if (mtim != 0) begin
               if (ctl_in_valid && qa.size() < QDEPTH) begin
                 qa.push_back(ctl_in_addr); qs.push_back(ctl_in_slots); qh.push_back(ctl_in_hops);
               end
               mtim--;
             end else mph = 2;
          2: if (qa.size() > 0) begin
               int f, a, s, h;
               a = qa.pop_front(); s = qs.pop_front(); h = qh.pop_front();
               f = (s << wt_l) - (h << wt_k);
               if (first != 0 || f > bf) begin bf = f; ba = a; end
               first = 0;
             end else begin
               mpa = ba; mpv = 1; mph = 3;
             end
          default: ;
        endcase
      end
      mt = tk ? 0 : mt + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R6 dest_valid", dest_valid, mdv);
      chk("R6 dest_addr", dest_addr, md);
      chk("R7 ctl_out_valid", ctl_out_valid, (mb < NSRC) ? 1 : 0);
      if (mb < NSRC) begin
        chk("R7 ctl_out_addr", ctl_out_addr, tbl_addr[mb]);
        chk("R7 ctl_out_hops", ctl_out_hops, tbl_hop[mb]);
        chk("R7 ctl_out_slots", ctl_out_slots, local_slots);
      end
    end
  end

  task automatic sync(int v);
    do @(negedge clk); while (mt != v);
  endtask

  task automatic send(int a, int s, int h);
    ctl_in_valid = 1'b1; ctl_in_addr = 4'(a); ctl_in_slots = 6'(s); ctl_in_hops = 4'(h);
    @(negedge clk);
    ctl_in_valid = 1'b0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dest_valid in reset", dest_valid, 0);
    chk("R1 ctl_out_valid in reset", ctl_out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dest_addr after reset", dest_addr, 0);
    chk("R1 no report in first period", ctl_out_valid, 0);

    sync(0);
    chk("R5 no winner yet", dest_valid, 0);
    chk("R7 first entry addr", ctl_out_addr, 12);
    chk("R7 first entry hops", ctl_out_hops, 5);
    local_slots = 6'd33;

    // R2: fits 12 and 0
    wt_l = 3'd1; wt_k = 3'd2;
    sync(0); send(5, 10, 2); send(9, 12, 6);
    sync(1); chk("R2 best fitness", dest_addr, 5); chk("R2 valid", dest_valid, 1);

    // R3: equal fits of 6
    wt_l = 3'd0; wt_k = 3'd0;
    sync(0); send(4, 8, 2); send(6, 9, 3);
    sync(1); chk("R3 tie earlier", dest_addr, 4);

    // R4: last accepted offset WINDOW-1
    sync(0); send(2, 1, 0); gap(WINDOW - 2); send(13, 5, 0); send(11, 30, 0);
    sync(1); chk("R4 window edge", dest_addr, 13);

    // R5: silent period
    sync(2); sync(1); chk("R5 retained", dest_addr, 13); chk("R5 valid kept", dest_valid, 1);

    // R8: fifth report dropped
    sync(0); send(1, 1, 0); send(2, 2, 0); send(3, 3, 0); send(4, 4, 0); send(7, 40, 0);
    sync(1); chk("R8 capacity", dest_addr, 4);

    // R10: fits -22 and -31
    wt_l = 3'd0; wt_k = 3'd3;
    sync(0); send(8, 2, 3); send(1, 1, 4);
    sync(1); chk("R10 signed", dest_addr, 8);

    // R9: report on the ending edge
    wt_l = 3'd0; wt_k = 3'd0;
    sync(INTERVAL - 1); send(15, 60, 0);
    sync(2); sync(1); chk("R9 ending edge ignored", dest_addr, 8);

    // R9: report after window closed
    sync(0); send(3, 4, 0); gap(30); send(14, 50, 0);
    sync(1); chk("R9 late ignored", dest_addr, 3);

    gap(4);
    finish_run();
  end
endmodule